// File: doc/BRIEF.md
# Shared-Adder Interleaved Row Accumulator

This block collects products from several parallel multiplier lanes into a result vector held on chip. Each product carries the index of the result row it belongs to. Lanes are grouped in pairs. Each pair owns one adder, which serves the even lane of the pair on one cycle and the odd lane on the next. A lane keeps a running sum for the row it is working on. When the row index changes, or when the input stream has ended, that sum is added into the result store with a read-modify-write.

One run goes through four phases. After reset or after the previous output, the store is zeroed entry by entry over the full vector length. It then accepts products until the done strobe arrives. It drains every skid buffer and every running sum. Last, it streams the complete vector out in ascending index order, one entry per cycle. While busy is high, no input is taken.

Top module: `lane_pair_accum`

## Requirements
- R1: While reset is held, and on the first cycle after it, busy is 1, out_valid is 0 and every bit of in_ready is 0.
- R2: After reset, and after every output stream, the block spends exactly VEC_LEN cycles zeroing the result store before busy falls. A run with no products therefore outputs zero in every entry, even if earlier runs stored non-zero sums.
- R3: Each output entry k equals the sum of all products accepted with row index k in that run, counted once each.
- R4: A row whose products come in separate bursts on a lane, with other rows in between, still gets the sum of all its bursts. A row that receives exactly one product outputs that product.
- R5: A lane takes a product only on a cycle where in_valid and in_ready are both 1. A product offered while in_ready is 0 is not taken and must be held by the source. After done, in_ready stays 0 until the next zeroing phase has finished.
- R6: The output stream has out_valid high for exactly VEC_LEN consecutive cycles, with out_index going 0, 1, …, VEC_LEN-1.
- R7: out_valid stays 0 while products are being accepted. It stays 0 until done has been given, and busy stays 1 from done until the last output entry.
- R8: The adder of a pair serves its two lanes on alternate cycles. No lane is served on two consecutive cycles, and the two lanes of a pair are never served on the same cycle.
- R9: Sums wrap modulo 2^ACC_W. Products are unsigned DATA_W-bit values, zero-extended before they are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | LANES | Per-lane product valid |
| in_prod | input | LANES*DATA_W | Per-lane product; lane l occupies bits l*DATA_W upward |
| in_row | input | LANES*IDX_W | Per-lane row index; lane l occupies bits l*IDX_W upward |
| in_ready | output | LANES | Per-lane accept; a product is taken when valid and ready are both 1 |
| done | input | 1 | One-cycle strobe: no further products this run |
| busy | output | 1 | High while zeroing, draining or streaming |
| out_valid | output | 1 | Output entry valid |
| out_index | output | IDX_W | Index of the output entry |
| out_value | output | ACC_W | Accumulated value of the output entry |

## Verification
The assertions take three things for granted about the inputs. Two lanes never carry the same row at the same time, so two pairs never write the same store entry in one cycle. The products of one row reach their lane as a contiguous group, or as separate groups that do not overlap another lane's use of that row. Done is given only once the source has no products left. The stimulus meets these conditions by tying every row to one lane (row mod 4 selects the lane) and by feeding each lane's rows in order. Valid is randomly dropped and held so that the skid buffers see both idle and full cycles. Done is strobed only after every queued product has been accepted.

// File: rtl/row_accum_pkg.sv
// Shared types for the interleaved row accumulator.
package row_accum_pkg;

    // Run phase of the accumulator.
    typedef enum logic [1:0] {
        PH_CLEAR = 2'd0,
        PH_ACCUM = 2'd1,
        PH_DRAIN = 2'd2,
        PH_EMIT  = 2'd3
    } phase_t;

    // What a pair's shared adder does in one cycle.
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_ADD   = 3'd1,  // extend running sum of the current row
        OP_SWAP  = 3'd2,  // commit old row to store, start new row
        OP_START = 3'd3,  // first product, nothing to commit
        OP_FLUSH = 3'd4   // end of stream: commit running sum
    } op_t;

endpackage

// File: rtl/lane_skid.sv
// Small per-lane FIFO that holds products while the lane waits for its
// adder turn. Assumes push is issued only while full is low.
module lane_skid #(
    parameter int W     = 20,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    assign head_valid = (cnt != '0);
    assign full       = (cnt == CW'(DEPTH));
    assign head       = slot[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // Data storage, written on push.
    always_ff @(posedge clk) begin
        if (push) slot[wr_ptr] <= din;
    end

    // R5: a push never lands on a full buffer.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CW'(DEPTH)) || pop);
    // R8: a lane is only served when it holds a product.
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt != '0);
endmodule

// File: rtl/pair_engine.sv
// One shared adder serving two lanes on alternate cycles. Each lane keeps a
// running sum for its current row. On a row change, or when draining, the
// adder adds the running sum into the store entry read through rd_idx.
// Assumes turn toggles every cycle and rows are not shared between lanes
// at the same time.
module pair_engine
    import row_accum_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24,
    parameter int IDX_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   turn,
    input  logic                   draining,
    input  logic [1:0]             head_valid,
    input  logic [1:0][DATA_W-1:0] head_prod,
    input  logic [1:0][IDX_W-1:0]  head_row,
    output logic [1:0]             pop,
    output logic [IDX_W-1:0]       rd_idx,
    input  logic [ACC_W-1:0]       rd_data,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [ACC_W-1:0]       wr_data,
    output logic                   idle
);
    logic [ACC_W-1:0] acc_q  [2];
    logic [IDX_W-1:0] row_q  [2];
    logic             live_q [2];

    op_t              op;
    logic [ACC_W-1:0] op_a, op_b, sum, prod_ext;
    logic             sel;

    assign sel      = turn;
    assign prod_ext = ACC_W'(head_prod[sel]);
    assign sum      = op_a + op_b;
    assign rd_idx   = row_q[sel];
    assign wr_idx   = row_q[sel];
    assign wr_data  = sum;
    assign wr_en    = (op == OP_SWAP) || (op == OP_FLUSH);
    assign idle     = !live_q[0] && !live_q[1];

    // Decide the adder's job for the lane whose turn it is.
    always_comb begin
        op = OP_IDLE;
        if (head_valid[sel]) begin
            if (live_q[sel] && row_q[sel] == head_row[sel]) op = OP_ADD;
            else if (live_q[sel])                           op = OP_SWAP;
            else                                            op = OP_START;
        end else if (draining && live_q[sel]) begin
            op = OP_FLUSH;
        end
    end

    // Select adder operands for the chosen job.
    always_comb begin
        op_a = '0;
        op_b = '0;
        unique case (op)
            OP_ADD:            begin op_a = acc_q[sel]; op_b = prod_ext;   end
            OP_SWAP, OP_FLUSH: begin op_a = rd_data;    op_b = acc_q[sel]; end
            default:           ;
        endcase
    end

    // Consume the head product of the served lane.
    always_comb begin
        pop      = '0;
        pop[sel] = (op == OP_ADD) || (op == OP_SWAP) || (op == OP_START);
    end

    // Running sum, row tag and live flag of each lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < 2; j++) begin
                acc_q[j]  <= '0;
                row_q[j]  <= '0;
                live_q[j] <= 1'b0;
            end
        end else begin
            unique case (op)
                OP_ADD: acc_q[sel] <= sum;
                OP_SWAP, OP_START: begin
                    acc_q[sel]  <= prod_ext;
                    row_q[sel]  <= head_row[sel];
                    live_q[sel] <= 1'b1;
                end
                OP_FLUSH: live_q[sel] <= 1'b0;
                default: ;
            endcase
        end
    end

    // R8: each lane is served at most every other cycle.
    a_r8_lane0_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        pop[0] |=> !pop[0]);
    a_r8_lane1_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        pop[1] |=> !pop[1]);
    // R3: a commit is always followed by the lane being free or on a new row.
    a_r3_commit_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !draining) |=> live_q[$past(sel)] && row_q[$past(sel)] != $past(wr_idx));
endmodule

// File: rtl/result_bank.sv
// Register-based result store: one write port per adder pair plus a clear
// port, combinational reads for each pair and for the output stream.
// Assumes two pairs never write the same entry in one cycle.
module result_bank #(
    parameter int VEC_LEN = 16,
    parameter int ACC_W   = 24,
    parameter int IDX_W   = 4,
    parameter int NPAIR   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_en,
    input  logic [IDX_W-1:0]            clr_idx,
    input  logic [NPAIR-1:0]            wr_en,
    input  logic [NPAIR-1:0][IDX_W-1:0] wr_idx,
    input  logic [NPAIR-1:0][ACC_W-1:0] wr_data,
    input  logic [NPAIR-1:0][IDX_W-1:0] rd_idx,
    output logic [NPAIR-1:0][ACC_W-1:0] rd_data,
    input  logic [IDX_W-1:0]            out_idx,
    output logic [ACC_W-1:0]            out_data
);
    logic [ACC_W-1:0] mem [VEC_LEN];

    // One storage process per entry: clear wins, else any matching pair write.
    for (genvar e = 0; e < VEC_LEN; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (clr_en && clr_idx == IDX_W'(e)) begin
                mem[e] <= '0;
            end else begin
                for (int p = 0; p < NPAIR; p++) begin
                    if (wr_en[p] && wr_idx[p] == IDX_W'(e)) mem[e] <= wr_data[p];
                end
            end
        end
    end

    // Read port per pair.
    for (genvar p = 0; p < NPAIR; p++) begin : g_rd
        assign rd_data[p] = mem[rd_idx[p]];
    end

    assign out_data = mem[out_idx];

    // R3: no two pairs update the same entry in the same cycle.
    for (genvar p = 0; p < NPAIR; p++) begin : g_chk_a
        for (genvar q = p + 1; q < NPAIR; q++) begin : g_chk_b
            a_r3_no_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[p] && wr_en[q]) |-> wr_idx[p] != wr_idx[q]);
        end
    end
    // R2: the clear port is never used together with an accumulate write.
    a_r2_clear_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> wr_en == '0);
endmodule

// File: rtl/phase_ctrl.sv
// Sequences one run: zero the store, accept products, drain lanes, stream
// the vector out, then start zeroing again. ptr walks the store index
// during zeroing and output.
module phase_ctrl
    import row_accum_pkg::*;
#(
    parameter int VEC_LEN = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             all_idle,
    output phase_t           phase,
    output logic [IDX_W-1:0] ptr,
    output logic             busy,
    output logic             clr_en,
    output logic             draining,
    output logic             out_valid
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(VEC_LEN - 1);

    assign busy      = (phase != PH_ACCUM);
    assign clr_en    = (phase == PH_CLEAR);
    assign draining  = (phase == PH_DRAIN);
    assign out_valid = (phase == PH_EMIT);

    // Phase sequencing and index walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_CLEAR;
            ptr   <= '0;
        end else begin
            unique case (phase)
                PH_CLEAR: begin
                    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
                    if (ptr == LAST) phase <= PH_ACCUM;
                end
                PH_ACCUM: if (done) phase <= PH_DRAIN;
                PH_DRAIN: if (all_idle) begin
                    phase <= PH_EMIT;
                    ptr   <= '0;
                end
                PH_EMIT: begin
                    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
                    if (ptr == LAST) phase <= PH_CLEAR;
                end
                default: phase <= PH_CLEAR;
            endcase
        end
    end

    // R2: accepting starts only after the last entry was zeroed.
    a_r2_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACCUM && $past(phase) == PH_CLEAR) |-> $past(ptr) == LAST);
    // R7: output begins only from the drain phase.
    a_r7_emit_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(phase) == PH_DRAIN);
endmodule

// File: rtl/lane_pair_accum.sv
// Top level: per-lane skid buffers, one shared-adder engine per lane pair,
// the result store and the phase controller. Assumes LANES is even and
// VEC_LEN is a power of two no smaller than 2.
module lane_pair_accum
    import row_accum_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 24,
    parameter int VEC_LEN = 16,
    parameter int SKID    = 2,
    parameter int IDX_W   = $clog2(VEC_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        in_valid,
    input  logic [LANES*DATA_W-1:0] in_prod,
    input  logic [LANES*IDX_W-1:0]  in_row,
    output logic [LANES-1:0]        in_ready,
    input  logic                    done,
    output logic                    busy,
    output logic                    out_valid,
    output logic [IDX_W-1:0]        out_index,
    output logic [ACC_W-1:0]        out_value
);
    localparam int NPAIR = LANES / 2;
    localparam int EW    = IDX_W + DATA_W;

    phase_t                    phase;
    logic [IDX_W-1:0]          ptr;
    logic                      clr_en, draining, all_idle, turn;
    logic [LANES-1:0]          head_valid, full, pop, push;
    logic [LANES-1:0][EW-1:0]  head;
    logic [NPAIR-1:0]          pair_idle, wr_en;
    logic [NPAIR-1:0][IDX_W-1:0] wr_idx, rd_idx;
    logic [NPAIR-1:0][ACC_W-1:0] wr_data, rd_data;

    // Alternating service slot shared by every pair.
    always_ff @(posedge clk) begin
        if (!rst_n) turn <= 1'b0;
        else        turn <= ~turn;
    end

    assign all_idle  = (head_valid == '0) && (&pair_idle);
    assign out_index = ptr;

    // Per-lane skid buffers.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign in_ready[l] = (phase == PH_ACCUM) && !full[l];
        assign push[l]     = in_valid[l] && in_ready[l];
        lane_skid #(.W(EW), .DEPTH(SKID)) u_skid (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (push[l]),
            .din        ({in_row[l*IDX_W +: IDX_W], in_prod[l*DATA_W +: DATA_W]}),
            .pop        (pop[l]),
            .head_valid (head_valid[l]),
            .head       (head[l]),
            .full       (full[l])
        );
    end

    // One shared adder per lane pair.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [1:0][DATA_W-1:0] hp;
        logic [1:0][IDX_W-1:0]  hr;
        for (genvar j = 0; j < 2; j++) begin : g_split
            assign hp[j] = head[2*p+j][DATA_W-1:0];
            assign hr[j] = head[2*p+j][EW-1:DATA_W];
        end
        pair_engine #(.DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_eng (
            .clk        (clk),
            .rst_n      (rst_n),
            .turn       (turn),
            .draining   (draining),
            .head_valid (head_valid[2*p +: 2]),
            .head_prod  (hp),
            .head_row   (hr),
            .pop        (pop[2*p +: 2]),
            .rd_idx     (rd_idx[p]),
            .rd_data    (rd_data[p]),
            .wr_en      (wr_en[p]),
            .wr_idx     (wr_idx[p]),
            .wr_data    (wr_data[p]),
            .idle       (pair_idle[p])
        );
        // R8: the two lanes of a pair are never served together.
        a_r8_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(pop[2*p] && pop[2*p+1]));
    end

    result_bank #(.VEC_LEN(VEC_LEN), .ACC_W(ACC_W), .IDX_W(IDX_W), .NPAIR(NPAIR)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (clr_en),
        .clr_idx  (ptr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .out_idx  (ptr),
        .out_data (out_value)
    );

    phase_ctrl #(.VEC_LEN(VEC_LEN), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .all_idle  (all_idle),
        .phase     (phase),
        .ptr       (ptr),
        .busy      (busy),
        .clr_en    (clr_en),
        .draining  (draining),
        .out_valid (out_valid)
    );

    // R6: consecutive output entries step the index by one.
    a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_index == $past(out_index) + 1'b1);
    // R5: nothing is accepted while busy.
    a_r5_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> push == '0);
    // R7: output only while busy.
    a_r7_out_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

// File: tb/tb_lane_pair_accum.sv
module tb_lane_pair_accum;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4, DW = 16, AW = 24, LEN = 16, IW = 4;
    localparam int QMAX  = 600;

    logic clk = 1'b0, rst_n = 1'b0, done = 1'b0;
    logic [LANES-1:0] in_valid = '0;
    logic [LANES*DW-1:0] in_prod = '0;
    logic [LANES*IW-1:0] in_row = '0;
    logic [LANES-1:0] in_ready;
    logic busy, out_valid;
    logic [IW-1:0] out_index;
    logic [AW-1:0] out_value;

    int total = 0, bad = 0, cyc = 0;
    int q_n [LANES];
    int unsigned q_row [LANES][QMAX];
    int unsigned q_prod[LANES][QMAX];
    int unsigned exp_v [LEN];
    bit feeding = 0, early = 0;

    lane_pair_accum #(.LANES(LANES), .DATA_W(DW), .ACC_W(AW), .VEC_LEN(LEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prod(in_prod),
        .in_row(in_row), .in_ready(in_ready), .done(done), .busy(busy),
        .out_valid(out_valid), .out_index(out_index), .out_value(out_value));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1; total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) if (feeding && out_valid) early = 1;

    task automatic check(bit ok, string req, int unsigned act, int unsigned expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic void clear_model();
        for (int l = 0; l < LANES; l++) q_n[l] = 0;
        for (int k = 0; k < LEN; k++) exp_v[k] = 0;
    endfunction

    // Queue a product on a lane and fold it into the expected sums (R9 wrap).
    function automatic void add_item(int l, int unsigned row, int unsigned prod);
        q_row[l][q_n[l]]  = row;
        q_prod[l][q_n[l]] = prod;
        q_n[l]++;
        exp_v[row] = (exp_v[row] + prod) & ((1 << AW) - 1);
    endfunction

    // Random run: row r belongs to lane r%4, rows fed in ascending order.
    function automatic void build_random();
        clear_model();
        for (int l = 0; l < LANES; l++)
            for (int r = l; r < LEN; r += LANES)
                if ($urandom % 4 != 0) begin
                    int n = 1 + ($urandom % 6);
                    for (int i = 0; i < n; i++) add_item(l, r, $urandom % 65536);
                end
    endfunction

    task automatic feed_and_done(string tag);
        int idx[LANES];
        bit fire[LANES];
        bit left;
        for (int l = 0; l < LANES; l++) idx[l] = 0;
        feeding = 1; early = 0;
        forever begin
            @(negedge clk);
            left = 0;
            for (int l = 0; l < LANES; l++) begin
                if (idx[l] < q_n[l]) begin
                    left = 1;
                    in_valid[l] = ($urandom % 4) != 0;
                    in_prod[l*DW +: DW] = DW'(q_prod[l][idx[l]]);
                    in_row[l*IW +: IW]  = IW'(q_row[l][idx[l]]);
                end else in_valid[l] = 1'b0;
            end
            if (!left) break;
            for (int l = 0; l < LANES; l++) fire[l] = in_valid[l] && in_ready[l];
            @(posedge clk);
            for (int l = 0; l < LANES; l++) if (fire[l]) idx[l]++;
        end
        check(!early, {"R7 no output during accept ", tag}, early, 0);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        feeding = 0;
        check(busy == 1'b1, {"R7 busy after done ", tag}, busy, 1);
        check(in_ready == '0, {"R5 ready low after done ", tag}, in_ready, 0);
    endtask

    task automatic collect(string tag);
        int w = 0;
        while (!out_valid && w < 5000) begin @(negedge clk); w++; end
        for (int k = 0; k < LEN; k++) begin
            check(out_valid == 1'b1, {"R6 valid run ", tag}, out_valid, 1);
            check(out_index == IW'(k), {"R6 index order ", tag}, out_index, k);
            check(out_value == AW'(exp_v[k]), {"R3 R4 R9 value ", tag}, out_value, exp_v[k]);
            if (k < LEN - 1) check(busy == 1'b1, {"R7 busy during output ", tag}, busy, 1);
            @(negedge clk);
        end
        check(out_valid == 1'b0, {"R6 stream length ", tag}, out_valid, 0);
    endtask

    task automatic wait_ready();
        int w = 0;
        while (busy && w < 5000) begin @(negedge clk); w++; end
    endtask

    initial begin
        int n;
        void'($urandom(32'h5eed_0042));
        clear_model();
        repeat (3) @(negedge clk);
        check(busy == 1'b1 && out_valid == 1'b0 && in_ready == '0, "R1 reset state", {busy, out_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b1 && in_ready == '0, "R1 first cycle after reset", busy, 1);
        n = 1;
        while (busy && n < 100) begin @(negedge clk); n++; end
        check(n == LEN, "R2 clear takes VEC_LEN cycles", n, LEN);

        // Empty run: every entry zero (R2).
        feed_and_done("empty");
        collect("empty");

        // Random runs (R3, R5, R8 via assertions).
        for (int t = 0; t < 3; t++) begin
            wait_ready();
            build_random();
            feed_and_done("random");
            collect("random");
        end

        // Directed: wrap, split bursts, single products (R4, R9).
        wait_ready();
        clear_model();
        for (int i = 0; i < 300; i++) add_item(0, 0, 16'hFFFF);  // R9 wrap
        add_item(0, 4, 7);
        for (int i = 0; i < 3; i++) add_item(1, 1, 100 + i);    // R4 burst one
        add_item(1, 5, 9);
        add_item(1, 5, 11);
        add_item(1, 1, 1000);                                    // R4 burst two
        add_item(1, 1, 2000);
        for (int r = 2; r < LEN; r += LANES) add_item(2, r, 50 + r); // R4 singles
        check(exp_v[0] == 2883284, "R9 model wrap value", exp_v[0], 2883284);
        feed_and_done("directed");
        collect("directed");

        // Empty run after non-zero data: store was re-zeroed (R2).
        wait_ready();
        clear_model();
        feed_and_done("empty again");
        collect("empty again");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule